// File: doc/BRIEF.md
# PC Sample Profiling Register Unit

This block lets an external debugger look at where a running processor is executing without stopping it. The core reports every retired instruction with its 64-bit address, its security state, its exception level and a hypervisor-context flag, and the block keeps the most recent one as a live sample. The debugger reads the sample as two 32-bit read-only words over a simple single-cycle read bus.

Reading the low word is the trigger. It returns the low address bits and, as a side effect, freezes a copy of the upper address bits and the context. A later high-word read then describes the same instruction even if the core has moved on. The side effect is suppressed when the software lock is set on a memory-mapped access. The low word returns an all-ones sentinel while the core is halted for debug, while profiling is prohibited, or while no instruction has retired since one of those conditions or a cold reset. Access is refused with an error response when the core is unpowered or either the double lock or the OS lock is set.

Top module: `pcs_prof_regs`

## Requirements
- R1: The low word sits at byte offset 0x0A0 and the high word at 0x0AC. The read response (`rd_data`, `rd_err`) for a read strobe in cycle N is presented in cycle N+1 and is zero in cycles with no read.
- R2: A permitted low-word read while the sample is valid and the core is neither halted nor prohibited returns bits [31:0] of the address carried by the most recent retirement strobe.
- R3: A permitted low-word read captures address bits [63:32], the non-secure flag, the exception level and the hypervisor flag of the live sample. Later high-word reads report that capture, not the newer retirements.
- R4: A low-word read with `mmio_path`=1 and `sw_lock`=1 still returns data, but leaves the captured high word and context unchanged.
- R5: While `core_halted`=1 or `prof_prohibit`=1, a permitted low-word read returns 0xFFFFFFFF.
- R6: The sample becomes invalid on a cold reset and in every cycle with `core_halted` or `prof_prohibit` high. It becomes valid again on the first later retirement strobe. While it is invalid, the low word reads 0xFFFFFFFF.
- R7: With `alt_fmt`=0, the high word returns captured address bits [63:32] when the captured hypervisor flag is 1, and zero when it is 0.
- R8: With `alt_fmt`=1, the high word is laid out as follows: bit 31 is the captured non-secure flag; bits 30:29 are the captured exception level (00 to 11 for levels 0 to 3); bits 28:24 are zero; bits 23:0 are captured address bits [55:32].
- R9: A read of either word while `core_pwr`=0, `dbl_lock`=1 or `os_lock`=1 gives `rd_err`=1 and `rd_data`=0, and has no capture side effect.
- R10: A write strobe at any offset changes no state and gives no response. A read at any other offset returns zero with `rd_err`=0.
- R11: While `rst_n` is low and for two clock edges after it rises, the outputs are zero, the captured values are zero and the sample is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, asynchronous, active low |
| ret_valid | input | 1 | Instruction retirement strobe |
| ret_addr | input | 64 | Retired instruction address |
| ret_nonsec | input | 1 | Retired instruction ran in non-secure state |
| ret_el | input | 2 | Exception level of retired instruction |
| ret_hyp | input | 1 | Hypervisor-context flag of retired instruction |
| core_halted | input | 1 | Core is in debug (halted) state |
| prof_prohibit | input | 1 | Sample-based profiling is prohibited |
| core_pwr | input | 1 | Core power domain is up |
| dbl_lock | input | 1 | Double lock set |
| os_lock | input | 1 | OS lock set |
| sw_lock | input | 1 | Software lock set |
| mmio_path | input | 1 | Current access comes through the memory-mapped port |
| alt_fmt | input | 1 | Selects the alternate high-word layout |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (ignored) |
| bus_addr | input | 12 | Byte offset of the access |
| rd_data | output | 32 | Read data, one cycle after the strobe |
| rd_err | output | 1 | Error response, one cycle after the strobe |

## Verification
Every read result is due exactly one clock edge after its strobe, because the response passes through one register stage. The capture from a low-word read is visible to a high-word read whose strobe comes in the very next cycle. A retirement or a halt in cycle N affects a low-word read whose strobe is in cycle N+1 or later. The bench drives inputs on the falling edge and updates its reference model on the rising edge from those same inputs. It compares `rd_data` and `rd_err` on the following falling edge, which is the cycle where the registered response stands. After reset is released, the bench waits out the two-edge synchronizer before it applies stimulus.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned PC_W    = 64;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned OFS_W   = 12;
  localparam int unsigned ALT_AW  = 24;
  localparam logic [OFS_W-1:0] OFS_LO = 12'h0A0;
  localparam logic [OFS_W-1:0] OFS_HI = 12'h0AC;

  typedef struct packed {
    logic       nonsec;
    logic [1:0] el;
    logic       hyp;
  } pcs_ctx_t;
endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pcs_live_sample.sv
module pcs_live_sample
  import pcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_valid,
  input  logic [PC_W-1:0] ret_addr,
  input  pcs_ctx_t        ret_ctx,
  input  logic            invalidate,
  output logic [PC_W-1:0] smp_addr,
  output pcs_ctx_t        smp_ctx,
  output logic            smp_valid
);
  logic [PC_W-1:0] addr_d;
  pcs_ctx_t        ctx_d;
  logic            valid_d;

  always_comb begin
    addr_d  = smp_addr;
    ctx_d   = smp_ctx;
    valid_d = smp_valid;
    if (ret_valid) begin
      addr_d  = ret_addr;
      ctx_d   = ret_ctx;
      valid_d = 1'b1;
    end
    if (invalidate) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_addr  <= '0;
      smp_ctx   <= '0;
      smp_valid <= 1'b0;
    end else begin
      smp_addr  <= addr_d;
      smp_ctx   <= ctx_d;
      smp_valid <= valid_d;
    end
  end

  // R6: halt or prohibit leaves the sample invalid
  a_r6_invalid_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate |=> !smp_valid);
  // R6: a strobe outside halt/prohibit validates the sample
  a_r6_valid_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !invalidate) |=> smp_valid);
endmodule

// File: rtl/pcs_snap_latch.sv
module pcs_snap_latch
  import pcs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_en,
  input  logic [PC_W-WORD_W-1:0] hi_in,
  input  pcs_ctx_t               ctx_in,
  output logic [PC_W-WORD_W-1:0] hi_q,
  output pcs_ctx_t               ctx_q
);
  logic [PC_W-WORD_W-1:0] hi_d;
  pcs_ctx_t               ctx_d;

  always_comb begin
    hi_d  = hi_q;
    ctx_d = ctx_q;
    if (cap_en) begin
      hi_d  = hi_in;
      ctx_d = ctx_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      ctx_q <= '0;
    end else begin
      hi_q  <= hi_d;
      ctx_q <= ctx_d;
    end
  end

  // R4/R9: without a capture request, the snapshot holds
  a_r4_snapshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(hi_q) && $stable(ctx_q)));
  // R3: a capture takes the live values
  a_r3_capture_taken: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (hi_q == $past(hi_in) && ctx_q == $past(ctx_in)));
endmodule

// File: rtl/pcs_rd_mux.sv
module pcs_rd_mux
  import pcs_pkg::*;
(
  input  logic                   rd_en,
  input  logic [OFS_W-1:0]       bus_addr,
  input  logic                   access_ok,
  input  logic                   no_side_fx,
  input  logic                   sentinel,
  input  logic                   alt_fmt,
  input  logic [WORD_W-1:0]      lo_live,
  input  logic [PC_W-WORD_W-1:0] hi_snap,
  input  pcs_ctx_t               ctx_snap,
  output logic [WORD_W-1:0]      data_d,
  output logic                   err_d,
  output logic                   cap_en
);
  localparam int unsigned PAD_W = WORD_W - ALT_AW - 3;

  logic hit_lo, hit_hi;
  logic [WORD_W-1:0] hi_word;

  assign hit_lo = rd_en && (bus_addr == OFS_LO);
  assign hit_hi = rd_en && (bus_addr == OFS_HI);

  always_comb begin
    if (alt_fmt)
      hi_word = {ctx_snap.nonsec, ctx_snap.el, {PAD_W{1'b0}}, hi_snap[ALT_AW-1:0]};
    else if (ctx_snap.hyp)
      hi_word = hi_snap;
    else
      hi_word = '0;
  end

  always_comb begin
    data_d = '0;
    err_d  = 1'b0;
    cap_en = 1'b0;
    if ((hit_lo || hit_hi) && !access_ok) begin
      err_d = 1'b1;
    end else if (hit_lo) begin
      data_d = sentinel ? '1 : lo_live;
      cap_en = !no_side_fx;
    end else if (hit_hi) begin
      data_d = hi_word;
    end
  end
endmodule

// File: rtl/pcs_prof_regs.sv
module pcs_prof_regs
  import pcs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ret_valid,
  input  logic [63:0] ret_addr,
  input  logic        ret_nonsec,
  input  logic [1:0]  ret_el,
  input  logic        ret_hyp,
  input  logic        core_halted,
  input  logic        prof_prohibit,
  input  logic        core_pwr,
  input  logic        dbl_lock,
  input  logic        os_lock,
  input  logic        sw_lock,
  input  logic        mmio_path,
  input  logic        alt_fmt,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [11:0] bus_addr,
  output logic [31:0] rd_data,
  output logic        rd_err
);
  logic                   rst_n_i;
  logic                   invalidate, access_ok, no_side_fx, sentinel;
  logic [PC_W-1:0]        smp_addr;
  pcs_ctx_t               smp_ctx, ret_ctx, ctx_snap;
  logic                   smp_valid, cap_en, err_d;
  logic [PC_W-WORD_W-1:0] hi_snap;
  logic [WORD_W-1:0]      data_d;
  logic                   wr_unused;

  assign wr_unused = wr_en;

  pcs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  assign ret_ctx    = '{nonsec: ret_nonsec, el: ret_el, hyp: ret_hyp};
  assign invalidate = core_halted || prof_prohibit;
  assign access_ok  = core_pwr && !dbl_lock && !os_lock;
  assign no_side_fx = mmio_path && sw_lock;
  assign sentinel   = invalidate || !smp_valid;

  pcs_live_sample u_live (
    .clk(clk), .rst_n(rst_n_i), .ret_valid(ret_valid), .ret_addr(ret_addr),
    .ret_ctx(ret_ctx), .invalidate(invalidate), .smp_addr(smp_addr),
    .smp_ctx(smp_ctx), .smp_valid(smp_valid));

  pcs_snap_latch u_snap (
    .clk(clk), .rst_n(rst_n_i), .cap_en(cap_en),
    .hi_in(smp_addr[PC_W-1:WORD_W]), .ctx_in(smp_ctx),
    .hi_q(hi_snap), .ctx_q(ctx_snap));

  pcs_rd_mux u_mux (
    .rd_en(rd_en), .bus_addr(bus_addr), .access_ok(access_ok),
    .no_side_fx(no_side_fx), .sentinel(sentinel), .alt_fmt(alt_fmt),
    .lo_live(smp_addr[WORD_W-1:0]), .hi_snap(hi_snap), .ctx_snap(ctx_snap),
    .data_d(data_d), .err_d(err_d), .cap_en(cap_en));

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else begin
      rd_data <= data_d;
      rd_err  <= err_d;
    end
  end

  // R9: an error response carries no data
  a_r9_err_no_data: assert property (@(posedge clk) disable iff (!rst_n_i)
    rd_err |-> (rd_data == '0));
  // R9: a blocked read of either word errors
  a_r9_blocked_errs: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_en && (bus_addr == OFS_LO || bus_addr == OFS_HI) && (!core_pwr || dbl_lock || os_lock))
    |=> rd_err);
  // R5: sentinel while halted or prohibited
  a_r5_sentinel: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_en && bus_addr == OFS_LO && core_pwr && !dbl_lock && !os_lock &&
     (core_halted || prof_prohibit)) |=> (rd_data == 32'hFFFF_FFFF));
  // R8: reserved bits of the alternate layout read zero
  a_r8_alt_pad_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_en && bus_addr == OFS_HI && alt_fmt) |=> (rd_data[28:24] == 5'd0));
  // R10: other offsets read zero without error
  a_r10_other_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_en && bus_addr != OFS_LO && bus_addr != OFS_HI) |=> (rd_data == '0 && !rd_err));
  // R1: no read, no response
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    !rd_en |=> (rd_data == '0 && !rd_err));
endmodule

// File: tb/sim_pcs_prof_regs.sv
module sim_pcs_prof_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ret_valid = 0, ret_nonsec = 0, ret_hyp = 0;
  logic [63:0] ret_addr = '0;
  logic [1:0] ret_el = '0;
  logic core_halted = 0, prof_prohibit = 0, core_pwr = 1, dbl_lock = 0, os_lock = 0;
  logic sw_lock = 0, mmio_path = 0, alt_fmt = 0, rd_en = 0, wr_en = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] rd_data;
  logic rd_err;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit m_valid;
  logic [63:0] m_addr; bit m_ns, m_hyp; logic [1:0] m_el;
  logic [31:0] s_hi; bit s_ns, s_hyp; logic [1:0] s_el;
  logic [31:0] e_data; bit e_err;
  string e_tag = "R11";

  always #10 clk = ~clk;

  pcs_prof_regs u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_valid = 0; m_addr = '0; m_ns = 0; m_hyp = 0; m_el = '0;
      s_hi = '0; s_ns = 0; s_hyp = 0; s_el = '0;
      e_data = '0; e_err = 0; e_tag = "R11";
    end else begin
      e_data = '0; e_err = 0; e_tag = "R1";
      if (rd_en && (bus_addr == 12'h0A0 || bus_addr == 12'h0AC)) begin
        if (!core_pwr || dbl_lock || os_lock) begin
          e_err = 1; e_tag = "R9";
        end else if (bus_addr == 12'h0A0) begin
          if (core_halted || prof_prohibit) begin e_data = '1; e_tag = "R5"; end
          else if (!m_valid) begin e_data = '1; e_tag = "R6"; end
          else begin e_data = m_addr[31:0]; e_tag = "R2"; end
          if (!(mmio_path && sw_lock)) begin
            s_hi = m_addr[63:32]; s_ns = m_ns; s_el = m_el; s_hyp = m_hyp;
          end
        end else if (alt_fmt) begin
          e_data = {s_ns, s_el, 5'b0, s_hi[23:0]}; e_tag = "R8";
        end else begin
          e_data = s_hyp ? s_hi : 32'h0; e_tag = "R7";
        end
      end else if (rd_en) e_tag = "R10";
      if (ret_valid) begin
        m_addr = ret_addr; m_ns = ret_nonsec; m_el = ret_el; m_hyp = ret_hyp; m_valid = 1;
      end
      if (core_halted || prof_prohibit) m_valid = 0;
    end
  end

  always @(negedge clk) if (!done) begin
    check(rd_data === e_data, e_tag, {32'h0, rd_data}, {32'h0, e_data});
    check(rd_err === e_err, e_tag, {63'h0, rd_err}, {63'h0, e_err});
  end

  always @(posedge clk) if (cyc > 20000 && !done) begin
    done = 1; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic retire(input logic [63:0] a, input bit ns, input logic [1:0] el, input bit hyp);
    ret_valid = 1; ret_addr = a; ret_nonsec = ns; ret_el = el; ret_hyp = hyp;
    @(negedge clk); ret_valid = 0;
  endtask

  // read, then return the response sampled one edge later
  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    rd_en = 1; bus_addr = a;
    @(negedge clk); rd_en = 0; bus_addr = '0;
    #1; d = rd_data; e = rd_err;
  endtask

  task automatic cold_reset();
    rst_n = 0; repeat (3) @(negedge clk);
    // R11: outputs zero during reset
    check(rd_data == 0 && rd_err == 0, "R11", {32'h0, rd_data}, 64'h0);
    rst_n = 1; repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d; logic e;
    cold_reset();
    // R6: nothing retired since reset
    rd(12'h0A0, d, e); check(d == 32'hFFFF_FFFF, "R6", {32'h0, d}, 64'hFFFF_FFFF);
    // R11: snapshot cleared by reset
    rd(12'h0AC, d, e); check(d == 0, "R11", {32'h0, d}, 64'h0);
    // R2/R3: coherent pair across a newer retirement
    retire(64'h1234_5678_9ABC_DEF0, 1, 2'd2, 1);
    rd(12'h0A0, d, e); check(d == 32'h9ABC_DEF0, "R2", {32'h0, d}, 64'h9ABC_DEF0);
    retire(64'hAAAA_BBBB_CCCC_DDDD, 0, 2'd1, 1);
    rd(12'h0AC, d, e); check(d == 32'h1234_5678, "R3", {32'h0, d}, 64'h1234_5678);
    // R8: alternate layout of the same snapshot
    alt_fmt = 1;
    rd(12'h0AC, d, e); check(d == {1'b1, 2'd2, 5'd0, 24'h34_5678}, "R8", {32'h0, d}, {32'h0, 1'b1, 2'd2, 5'd0, 24'h34_5678});
    alt_fmt = 0;
    // R4: locked memory-mapped read does not capture
    sw_lock = 1; mmio_path = 1;
    rd(12'h0A0, d, e); check(d == 32'hCCCC_DDDD, "R4", {32'h0, d}, 64'hCCCC_DDDD);
    rd(12'h0AC, d, e); check(d == 32'h1234_5678, "R4", {32'h0, d}, 64'h1234_5678);
    mmio_path = 0;
    rd(12'h0A0, d, e);
    rd(12'h0AC, d, e); check(d == 32'hAAAA_BBBB, "R3", {32'h0, d}, 64'hAAAA_BBBB);
    sw_lock = 0;
    // R7: hypervisor flag clear reads zero
    retire(64'h5555_6666_7777_8888, 0, 2'd0, 0);
    rd(12'h0A0, d, e);
    rd(12'h0AC, d, e); check(d == 0, "R7", {32'h0, d}, 64'h0);
    // R5 and R6: halt, then no retirement
    core_halted = 1;
    rd(12'h0A0, d, e); check(d == 32'hFFFF_FFFF, "R5", {32'h0, d}, 64'hFFFF_FFFF);
    core_halted = 0;
    rd(12'h0A0, d, e); check(d == 32'hFFFF_FFFF, "R6", {32'h0, d}, 64'hFFFF_FFFF);
    retire(64'h0000_0001_0000_0040, 0, 2'd1, 1);
    rd(12'h0A0, d, e); check(d == 32'h40, "R6", {32'h0, d}, 64'h40);
    prof_prohibit = 1; @(negedge clk); prof_prohibit = 0;
    rd(12'h0A0, d, e); check(d == 32'hFFFF_FFFF, "R6", {32'h0, d}, 64'hFFFF_FFFF);
    // R9: blocked access, no capture
    retire(64'h9999_0000_0000_0100, 0, 2'd3, 1);
    os_lock = 1; rd(12'h0A0, d, e); check(e == 1 && d == 0, "R9", {31'h0, e, d}, {31'h0, 1'b1, 32'h0}); os_lock = 0;
    dbl_lock = 1; rd(12'h0AC, d, e); check(e == 1, "R9", {63'h0, e}, 64'h1); dbl_lock = 0;
    core_pwr = 0; rd(12'h0A0, d, e); check(e == 1, "R9", {63'h0, e}, 64'h1); core_pwr = 1;
    rd(12'h0AC, d, e); check(d == 32'h1, "R9", {32'h0, d}, 64'h1);
    // R10: writes ignored, other offsets zero
    wr_en = 1; bus_addr = 12'h0A0; @(negedge clk); bus_addr = 12'h0AC; @(negedge clk); wr_en = 0;
    check(rd_data == 0 && rd_err == 0, "R10", {32'h0, rd_data}, 64'h0);
    rd(12'h0AC, d, e); check(d == 32'h1, "R10", {32'h0, d}, 64'h1);
    rd(12'h0A4, d, e); check(d == 0 && e == 0, "R10", {31'h0, e, d}, 64'h0);
    // mixed traffic against the model
    for (int i = 0; i < 2000; i++) begin
      ret_valid = $urandom_range(0, 1);
      ret_addr = {$urandom, $urandom}; ret_nonsec = $urandom_range(0, 1);
      ret_el = 2'($urandom_range(0, 3)); ret_hyp = $urandom_range(0, 1);
      core_halted = ($urandom_range(0, 15) == 0); prof_prohibit = ($urandom_range(0, 15) == 0);
      core_pwr = ($urandom_range(0, 15) != 0); dbl_lock = ($urandom_range(0, 15) == 0);
      os_lock = ($urandom_range(0, 15) == 0); sw_lock = $urandom_range(0, 1);
      mmio_path = $urandom_range(0, 1); alt_fmt = $urandom_range(0, 1);
      rd_en = $urandom_range(0, 1); wr_en = $urandom_range(0, 1);
      case ($urandom_range(0, 4))
        0, 1: bus_addr = 12'h0A0;
        2, 3: bus_addr = 12'h0AC;
        default: bus_addr = 12'($urandom);
      endcase
      @(negedge clk);
    end
    ret_valid = 0; rd_en = 0; wr_en = 0; core_halted = 0; prof_prohibit = 0;
    core_pwr = 1; dbl_lock = 0; os_lock = 0;
    // R11: cold reset mid-run invalidates the sample
    cold_reset();
    rd(12'h0A0, d, e); check(d == 32'hFFFF_FFFF, "R11", {32'h0, d}, 64'hFFFF_FFFF);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule